// File: doc/BRIEF.md
# Prefix-Coded Instruction Decoder

This block turns one 16-bit instruction word into the control bundle for a 32-bit core with sixteen registers. Opcodes have three lengths, told apart by their leading bits: a top nibble of 0000 to 1010 is a complete 4-bit opcode; 1110 is followed by a second opcode nibble; 1111 followed by 00 is followed by a 4-bit branch sub-opcode. All fields are counted from bit 15 downward, so the opcode always starts at the top of the word.

The decoder has no clock and no state. The word on its input is decoded in the same cycle. It produces an ALU operation, the destination and two source register indices, a zero-extended 8-bit immediate with a flag that selects it as the second operand, a register write enable, a memory read or write request with an access size, and a branch condition with a link flag. Memory is little-endian. Halfword and byte loads are meant to be zero-extended to 32 bits by the load path; the size code tells that path which width to use. Any word that matches no instruction raises the illegal output, and every enable is then low.

Top module: `pfx_instr_decoder`

## Requirements
- R1: Top nibble 0001, 0011, 0101, 0110, 0111, 1000 or 1010 decodes as a three-register operation. alu_op is 1 (add), 2 (sub), 3 (shl), 4 (shr), 5 (or), 6 (and) or 8 (xor) in that order. rd is bits 11:8, rs1 is bits 7:4, rs2 is bits 3:0. reg_we is 1, use_imm is 0 and imm is 0.
- R2: Top nibble 0000, 0010 or 0100 decodes as an immediate operation with alu_op 1 (add), 2 (sub) or 9 (pass operand B). rd and rs1 are both bits 11:8. rs2 is 0. imm is bits 7:0 zero-extended to 32 bits. use_imm and reg_we are 1.
- R3: Top nibble 1001 gives alu_op 7 (invert), rd bits 11:8 and rs1 bits 7:4. rs2 is 0 whatever bits 3:0 hold, and reg_we is 1.
- R4: Word 1110_0000 gives a register copy: alu_op 9, rd bits 7:4, rs2 bits 3:0, rs1 0, reg_we 1, and no memory request.
- R5: Words 1110_0001, 1110_0011 and 1110_0101 are loads of size word, halfword and byte (mem_size 2, 1, 0). For each: mem_rd is 1, alu_op is 10 (pass operand A), rs1 is bits 3:0 (the address), rd is bits 7:4 and reg_we is 1.
- R6: Words 1110_0010, 1110_0100 and 1110_0110 are stores of size word, halfword and byte (mem_size 2, 1, 0). For each: mem_wr is 1, alu_op is 10, rs1 is bits 3:0 (the address), rs2 is bits 7:4 (the data), and rd and reg_we are 0.
- R7: Word 1110_0111 is a compare: alu_op 2, rs1 bits 7:4, rs2 bits 3:0, with no register write and no memory request.
- R8: A word with bits 15:10 equal to 1111_00 and a sub-opcode in bits 9:6 of at most 0110 is a branch. br_valid is 1, br_cond is the sub-opcode (0 always, 1 equal, 2 not equal, 3 greater, 4 greater-or-equal, 5 less, 6 less-or-equal), br_link is bit 5, and rs1 is bits 3:0. Bit 4 has no effect, and there is no register write and no memory request.
- R9: Every other word raises illegal. This covers top nibbles 1011, 1100 and 1101, 1110 with a second nibble above 0111, 1111 with bits 11:10 not 00, and branch sub-opcodes above 0110. All other outputs are then 0.
- R10: mem_rd and mem_wr are never both 1, mem_size is 0 when neither is 1, and an unused field output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Instruction word |
| alu_op_o | output | 4 | ALU operation code |
| rd_o | output | 4 | Destination register index |
| rs1_o | output | 4 | First source register index (address for memory access) |
| rs2_o | output | 4 | Second source register index (data for stores) |
| imm_o | output | 32 | Zero-extended immediate |
| use_imm_o | output | 1 | Second ALU operand comes from imm_o |
| reg_we_o | output | 1 | Register file write enable |
| mem_rd_o | output | 1 | Memory load request |
| mem_wr_o | output | 1 | Memory store request |
| mem_size_o | output | 2 | Access size: 0 byte, 1 halfword, 2 word |
| br_valid_o | output | 1 | Word is a branch |
| br_cond_o | output | 3 | Branch condition code |
| br_link_o | output | 1 | Branch saves its return address |
| illegal_o | output | 1 | Word matches no instruction |

## Verification
The hardest cases are at the edges of the prefix classes. Examples are a 1111 word whose bits 11:10 are not 00, a branch sub-opcode of 0111, and the reserved branch bit or the ignored last nibble of the invert form that toggles while the other fields stay fixed. Random or per-class stimulus hits these only by chance. So the bench sweeps all 65536 instruction words in order, one per clock. It compares each decode against a behavioural model written with plain integers, and it checks the mutual-exclusion rules on every word as well.

// File: rtl/pfx_dec_pkg.sv
package pfx_dec_pkg;

    localparam int INSTR_W = 16;
    localparam int NIB_W   = 4;
    localparam int REG_W   = 4;
    localparam int DATA_W  = 32;
    localparam int IMM_W   = 8;
    localparam int ALU_W   = 4;
    localparam int SIZE_W  = 2;
    localparam int COND_W  = 3;

    localparam int SHORT_LAST = 10;
    localparam int EXT_LAST   = 7;
    localparam int BR_LAST    = 6;

    localparam logic [NIB_W-1:0] PFX_EXT = 4'hE;
    localparam logic [NIB_W-1:0] PFX_BR  = 4'hF;

    typedef logic [REG_W-1:0] reg_idx_t;

    typedef enum logic [ALU_W-1:0] {
        ALU_NONE   = 4'd0,
        ALU_ADD    = 4'd1,
        ALU_SUB    = 4'd2,
        ALU_SHL    = 4'd3,
        ALU_SHR    = 4'd4,
        ALU_OR     = 4'd5,
        ALU_AND    = 4'd6,
        ALU_NOT    = 4'd7,
        ALU_XOR    = 4'd8,
        ALU_PASS_B = 4'd9,
        ALU_PASS_A = 4'd10
    } alu_op_e;

    typedef enum logic [SIZE_W-1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } mem_size_e;

    typedef struct packed {
        logic [NIB_W-1:0] top;
        logic [NIB_W-1:0] n2;
        logic [NIB_W-1:0] n1;
        logic [NIB_W-1:0] n0;
    } nibbles_t;

    typedef struct packed {
        alu_op_e           alu_op;
        reg_idx_t          rd;
        reg_idx_t          rs1;
        reg_idx_t          rs2;
        logic [DATA_W-1:0] imm;
        logic              use_imm;
        logic              reg_we;
        logic              mem_rd;
        logic              mem_wr;
        mem_size_e         mem_size;
        logic              br_valid;
        logic [COND_W-1:0] br_cond;
        logic              br_link;
    } ctrl_t;

    function automatic ctrl_t ctrl_idle();
        ctrl_t c;
        c          = '0;
        c.alu_op   = ALU_NONE;
        c.mem_size = SZ_BYTE;
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] zext_imm(input logic [IMM_W-1:0] v);
        return {{(DATA_W-IMM_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/pfx_short_dec.sv
module pfx_short_dec
    import pfx_dec_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output ctrl_t              ctrl_o,
    output logic               hit_o
);

    nibbles_t f;
    assign f = nibbles_t'(instr_i);

    always_comb begin
        ctrl_o = ctrl_idle();
        hit_o  = (int'(f.top) <= SHORT_LAST);
        if (hit_o) begin
            ctrl_o.rd     = f.n2;
            ctrl_o.reg_we = 1'b1;
            case (f.top)
                4'h0, 4'h2, 4'h4: begin
                    ctrl_o.rs1     = f.n2;
                    ctrl_o.imm     = zext_imm({f.n1, f.n0});
                    ctrl_o.use_imm = 1'b1;
                    ctrl_o.alu_op  = (f.top == 4'h0) ? ALU_ADD :
                                     (f.top == 4'h2) ? ALU_SUB : ALU_PASS_B;
                end
                default: begin
                    ctrl_o.rs1 = f.n1;
                    ctrl_o.rs2 = (f.top == 4'h9) ? '0 : f.n0;
                    case (f.top)
                        4'h1:    ctrl_o.alu_op = ALU_ADD;
                        4'h3:    ctrl_o.alu_op = ALU_SUB;
                        4'h5:    ctrl_o.alu_op = ALU_SHL;
                        4'h6:    ctrl_o.alu_op = ALU_SHR;
                        4'h7:    ctrl_o.alu_op = ALU_OR;
                        4'h8:    ctrl_o.alu_op = ALU_AND;
                        4'h9:    ctrl_o.alu_op = ALU_NOT;
                        default: ctrl_o.alu_op = ALU_XOR;
                    endcase
                end
            endcase
        end
    end

    always_comb begin
        // R3
        not_rs2_chk: assert (!(hit_o && f.top == 4'h9) || ctrl_o.rs2 == '0);
        // R2
        imm_gated_chk: assert (ctrl_o.use_imm || ctrl_o.imm == '0);
    end

endmodule

// File: rtl/pfx_ext_dec.sv
module pfx_ext_dec
    import pfx_dec_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output ctrl_t              ctrl_o,
    output logic               hit_o
);

    nibbles_t f;
    assign f = nibbles_t'(instr_i);

    function automatic mem_size_e size_of(input logic [2:0] sub);
        case (sub)
            3'd1, 3'd2: return SZ_WORD;
            3'd3, 3'd4: return SZ_HALF;
            default:    return SZ_BYTE;
        endcase
    endfunction

    always_comb begin
        ctrl_o = ctrl_idle();
        hit_o  = (f.top == PFX_EXT) && (int'(f.n2) <= EXT_LAST);
        if (hit_o) begin
            case (f.n2[2:0])
                3'd0: begin
                    ctrl_o.alu_op = ALU_PASS_B;
                    ctrl_o.rd     = f.n1;
                    ctrl_o.rs2    = f.n0;
                    ctrl_o.reg_we = 1'b1;
                end
                3'd1, 3'd3, 3'd5: begin
                    ctrl_o.alu_op   = ALU_PASS_A;
                    ctrl_o.rd       = f.n1;
                    ctrl_o.rs1      = f.n0;
                    ctrl_o.reg_we   = 1'b1;
                    ctrl_o.mem_rd   = 1'b1;
                    ctrl_o.mem_size = size_of(f.n2[2:0]);
                end
                3'd2, 3'd4, 3'd6: begin
                    ctrl_o.alu_op   = ALU_PASS_A;
                    ctrl_o.rs1      = f.n0;
                    ctrl_o.rs2      = f.n1;
                    ctrl_o.mem_wr   = 1'b1;
                    ctrl_o.mem_size = size_of(f.n2[2:0]);
                end
                default: begin
                    ctrl_o.alu_op = ALU_SUB;
                    ctrl_o.rs1    = f.n1;
                    ctrl_o.rs2    = f.n0;
                end
            endcase
        end
    end

    always_comb begin
        // R6
        store_no_we_chk: assert (!ctrl_o.mem_wr || !ctrl_o.reg_we);
        // R5
        load_we_chk: assert (!ctrl_o.mem_rd || ctrl_o.reg_we);
    end

endmodule

// File: rtl/pfx_branch_dec.sv
module pfx_branch_dec
    import pfx_dec_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output ctrl_t              ctrl_o,
    output logic               hit_o
);

    localparam int SUB_LO = REG_W + 2;
    localparam int SUB_HI = SUB_LO + NIB_W - 1;

    logic [NIB_W-1:0] sub;
    logic [1:0]       gap;
    logic             reserved_bit;

    assign sub          = instr_i[SUB_HI:SUB_LO];
    assign gap          = instr_i[INSTR_W-NIB_W-1 -: 2];
    assign reserved_bit = instr_i[REG_W];

    always_comb begin
        ctrl_o = ctrl_idle();
        hit_o  = (instr_i[INSTR_W-1 -: NIB_W] == PFX_BR) && (gap == 2'b00)
                 && (int'(sub) <= BR_LAST);
        if (hit_o) begin
            ctrl_o.br_valid = 1'b1;
            ctrl_o.br_cond  = sub[COND_W-1:0];
            ctrl_o.br_link  = instr_i[REG_W+1];
            ctrl_o.rs1      = instr_i[REG_W-1:0];
        end
    end

    logic unused_bits;
    assign unused_bits = reserved_bit;

    always_comb begin
        // R8
        br_quiet_chk: assert (!ctrl_o.br_valid || (!ctrl_o.reg_we && !ctrl_o.mem_rd && !ctrl_o.mem_wr));
    end

endmodule

// File: rtl/pfx_instr_decoder.sv
module pfx_instr_decoder
    import pfx_dec_pkg::*;
(
    input  logic [15:0] instr_i,
    output logic [3:0]  alu_op_o,
    output logic [3:0]  rd_o,
    output logic [3:0]  rs1_o,
    output logic [3:0]  rs2_o,
    output logic [31:0] imm_o,
    output logic        use_imm_o,
    output logic        reg_we_o,
    output logic        mem_rd_o,
    output logic        mem_wr_o,
    output logic [1:0]  mem_size_o,
    output logic        br_valid_o,
    output logic [2:0]  br_cond_o,
    output logic        br_link_o,
    output logic        illegal_o
);

    ctrl_t short_c, ext_c, br_c, sel_c;
    logic  short_hit, ext_hit, br_hit;

    pfx_short_dec  u_short  (.instr_i(instr_i), .ctrl_o(short_c), .hit_o(short_hit));
    pfx_ext_dec    u_ext    (.instr_i(instr_i), .ctrl_o(ext_c),   .hit_o(ext_hit));
    pfx_branch_dec u_branch (.instr_i(instr_i), .ctrl_o(br_c),    .hit_o(br_hit));

    always_comb begin
        if (short_hit)      sel_c = short_c;
        else if (ext_hit)   sel_c = ext_c;
        else if (br_hit)    sel_c = br_c;
        else                sel_c = ctrl_idle();
    end

    assign illegal_o  = !(short_hit || ext_hit || br_hit);
    assign alu_op_o   = sel_c.alu_op;
    assign rd_o       = sel_c.rd;
    assign rs1_o      = sel_c.rs1;
    assign rs2_o      = sel_c.rs2;
    assign imm_o      = sel_c.imm;
    assign use_imm_o  = sel_c.use_imm;
    assign reg_we_o   = sel_c.reg_we;
    assign mem_rd_o   = sel_c.mem_rd;
    assign mem_wr_o   = sel_c.mem_wr;
    assign mem_size_o = sel_c.mem_size;
    assign br_valid_o = sel_c.br_valid;
    assign br_cond_o  = sel_c.br_cond;
    assign br_link_o  = sel_c.br_link;

    always_comb begin
        // R9
        class_onehot_chk: assert ($onehot0({short_hit, ext_hit, br_hit}));
        // R9
        illegal_quiet_chk: assert (!illegal_o || (!reg_we_o && !mem_rd_o && !mem_wr_o && !br_valid_o));
        // R10
        mem_excl_chk: assert (!(mem_rd_o && mem_wr_o));
        // R10
        size_idle_chk: assert (mem_rd_o || mem_wr_o || mem_size_o == 2'd0);
    end

endmodule

// File: tb/sim_pfx_instr_decoder.sv
`timescale 1ns/1ps
module sim_pfx_instr_decoder;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [15:0] instr = 16'h0000;
    logic [3:0]  alu_op, rd, rs1, rs2;
    logic [31:0] imm;
    logic        use_imm, reg_we, mem_rd, mem_wr, br_valid, br_link, illegal;
    logic [1:0]  mem_size;
    logic [2:0]  br_cond;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    pfx_instr_decoder u0 (
        .instr_i(instr), .alu_op_o(alu_op), .rd_o(rd), .rs1_o(rs1), .rs2_o(rs2),
        .imm_o(imm), .use_imm_o(use_imm), .reg_we_o(reg_we), .mem_rd_o(mem_rd),
        .mem_wr_o(mem_wr), .mem_size_o(mem_size), .br_valid_o(br_valid),
        .br_cond_o(br_cond), .br_link_o(br_link), .illegal_o(illegal)
    );

    // Behavioural model: {alu,rd,rs1,rs2,imm,use_imm,we,mrd,mwr,size,bv,cond,link,ill}
    function automatic logic [59:0] ref_dec(input int w);
        int t, a, b, c, sub;
        int alu, xd, x1, x2, im, ui, we, mr, mw, sz, bv, bc, lk, il;
        t = (w >> 12) & 15; a = (w >> 8) & 15; b = (w >> 4) & 15; c = w & 15;
        sub = (w >> 6) & 15;
        alu = 0; xd = 0; x1 = 0; x2 = 0; im = 0; ui = 0; we = 0;
        mr = 0; mw = 0; sz = 0; bv = 0; bc = 0; lk = 0; il = 0;
        if (t <= 10) begin
            xd = a; we = 1;
            if (t == 0 || t == 2 || t == 4) begin
                x1 = a; im = w & 255; ui = 1;
                alu = (t == 0) ? 1 : (t == 2) ? 2 : 9;
            end else begin
                x1 = b; x2 = (t == 9) ? 0 : c;
                case (t)
                    1: alu = 1;  3: alu = 2;  5: alu = 3;  6: alu = 4;
                    7: alu = 5;  8: alu = 6;  9: alu = 7;  default: alu = 8;
                endcase
            end
        end else if (t == 14 && a <= 7) begin
            if (a == 0) begin alu = 9; xd = b; x2 = c; we = 1; end
            else if (a == 7) begin alu = 2; x1 = b; x2 = c; end
            else begin
                alu = 10; x1 = c;
                sz = (a <= 2) ? 2 : (a <= 4) ? 1 : 0;
                if (a % 2 == 1) begin mr = 1; xd = b; we = 1; end
                else begin mw = 1; x2 = b; end
            end
        end else if (t == 15 && (a >> 2) == 0 && sub <= 6) begin
            bv = 1; bc = sub; lk = (w >> 5) & 1; x1 = c;
        end else begin
            il = 1;
        end
        return {4'(alu), 4'(xd), 4'(x1), 4'(x2), 32'(im), 1'(ui), 1'(we),
                1'(mr), 1'(mw), 2'(sz), 1'(bv), 3'(bc), 1'(lk), 1'(il)};
    endfunction

    function automatic string req_of(input int w);
        int t, a;
        t = (w >> 12) & 15; a = (w >> 8) & 15;
        if (t == 0 || t == 2 || t == 4) return "R2";
        if (t == 9) return "R3";
        if (t <= 10) return "R1";
        if (t == 14 && a == 0) return "R4";
        if (t == 14 && (a == 1 || a == 3 || a == 5)) return "R5";
        if (t == 14 && (a == 2 || a == 4 || a == 6)) return "R6";
        if (t == 14 && a == 7) return "R7";
        if (ref_dec(w)[5]) return "R8";
        return "R9";
    endfunction

    task automatic check_word(input int w, input string tag);
        logic [59:0] got, exp;
        got = {alu_op, rd, rs1, rs2, imm, use_imm, reg_we, mem_rd, mem_wr,
               mem_size, br_valid, br_cond, br_link, illegal};
        exp = ref_dec(w);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s word=%04h actual=%015h expected=%015h", tag, w, got, exp);
        end
        checks++;
        if ((mem_rd && mem_wr) || (!mem_rd && !mem_wr && mem_size != 2'd0)) begin
            fails++;
            $display("FAIL R10 word=%04h actual rd=%0b wr=%0b size=%0d expected exclusive/idle size 0",
                     w, mem_rd, mem_wr, mem_size);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_word(0, "R2 reset-word");
        for (int w = 0; w < 65536; w++) begin
            @(posedge clk);
            instr = 16'(w);
            @(negedge clk);
            check_word(w, req_of(w));
        end
        // R3 and R8 spot checks: ignored bits toggled with other fields fixed
        @(posedge clk); instr = 16'h9A5F; @(negedge clk); check_word(32'h9A5F, "R3");
        @(posedge clk); instr = 16'h9A50; @(negedge clk); check_word(32'h9A50, "R3");
        @(posedge clk); instr = 16'hF1A7; @(negedge clk); check_word(32'hF1A7, "R8");
        @(posedge clk); instr = 16'hF1B7; @(negedge clk); check_word(32'hF1B7, "R8");
        @(posedge clk); instr = 16'hF1C7; @(negedge clk); check_word(32'hF1C7, "R9");
        @(posedge clk); instr = 16'hF407; @(negedge clk); check_word(32'hF407, "R9");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule